// File: doc/BRIEF.md
# Gated Divided Clock Buffer

This block takes one input clock and drives a clock output at the input rate divided by an integer from 1 to 8. A 3-bit select picks the ratio. A clear input stops the output Low. The clear acts at once when it is raised, but its release passes through a two-stage synchronizer on the input clock. An enable input freezes the output level and the divide counter wherever they are. Both edges of the enable are synchronized, and on re-enable the block resumes from the exact count it held.

Two mask inputs set how the buffer reacts to its controls. With the clear mask set, the clear input is ignored. With the enable mask set, the enable input is ignored. The divide select and both masks are captured only on input-clock edges at which the clear input is High, so the usual sequence is: raise clear, set the configuration, then release clear. In divide-by-1 the output is the input clock, gated through a register that changes on the falling edge. For every other ratio the output comes straight from a register. Either way, no combinational glitch reaches the output.

This is a clock primitive with no data path, so there is no valid/ready interface and every pin is plain control.

Top module: `gated_div_clkbuf`

## Requirements
- R1: For a captured select value S from 1 to 7, the output is periodic with a period of exactly S+1 input cycles.
- R2: Within each period of a divide N ≥ 2 the output is High for floor(N/2) input cycles and Low for the remaining ceil(N/2) cycles. Divide-by-7 therefore gives 3 High and 4 Low.
- R3: Let clear be released between input edges, and call the next three rising edges E0, E1 and E2. The output stays Low after E0 and E1 and goes High after E2. It first falls floor(N/2) cycles after E2.
- R4: Raising the unmasked clear drives the output Low at once, with no input-clock edge needed. The output then stays Low while clear is held.
- R5: Take enable dropping between edges, with the next edges numbered 0, 1, 2 and so on. The counter still advances on edges 0 and 1. From edge 2 onward the output level and the count are frozen. After enable returns, the count resumes from the frozen value on the third rising edge.
- R6: With a clear mask of 1 captured, a High clear input neither stops nor resets the output. Capturing a clear mask of 0 while clear is High returns the block to clear on the next edge.
- R7: With an enable mask of 1 captured, the block runs as if enable were High, even when the enable input is Low.
- R8: Changes to the divide select or to either mask while the clear input is Low have no effect until the next time clear is held.
- R9: With select 0 (divide-by-1) the output equals the input clock while running. It is Low during clear, Low during the input's Low phase, and Low from the third rising edge after enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to divide and gate |
| clr | input | 1 | Clear, active High: asynchronous assertion, synchronized release |
| ce | input | 1 | Clock enable, active High, synchronized on both edges |
| clr_mask | input | 1 | When captured as 1, clear is ignored |
| ce_mask | input | 1 | When captured as 1, enable is treated as High |
| div_sel | input | 3 | Divide ratio minus one, captured while clear is High |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
All eight select values are tried in turn from a fresh clear release. Each run checks the release latency and two full output periods, which tells apart an off-by-one in the ratio, a wrong High/Low split on odd ratios, and a wrong synchronizer depth. Further patterns do the following:
- An enable drop on a High divide-by-8 phase shows whether the counter freezes and resumes from its held position, or restarts from zero.
- A clear raised mid-High phase tells a true asynchronous assertion apart from a clocked one.
- A select change made outside clear shows whether the configuration is really held.
- Masked runs show whether the ignored control still leaks through.

// File: rtl/gdcb_pkg.sv
`timescale 1ns/1ps
package gdcb_pkg;
  localparam int DIV_W = 3;

  typedef logic [DIV_W-1:0] div_sel_t;

  typedef struct packed {
    div_sel_t div_m1;
    logic     ce_bypass;
    logic     clr_bypass;
  } hold_cfg_t;
endpackage

// File: rtl/gdcb_sync.sv
`timescale 1ns/1ps
module gdcb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) stg <= '0;
    else      stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gdcb_cfg.sv
`timescale 1ns/1ps
module gdcb_cfg (
  input  logic                 clk,
  input  logic                 clr_raw,
  input  gdcb_pkg::hold_cfg_t  cfg_in,
  output gdcb_pkg::hold_cfg_t  cfg_q
);
  // configuration is only taken while the raw clear input is High
  always_ff @(posedge clk) begin
    if (clr_raw) cfg_q <= cfg_in;
  end

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (clr_raw)
    !clr_raw |=> $stable(cfg_q));
endmodule

// File: rtl/gdcb_divider.sv
`timescale 1ns/1ps
module gdcb_divider #(
  parameter int DIV_W = gdcb_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             run,
  input  logic             en,
  input  logic [DIV_W-1:0] div_m1,
  output logic             pulse_q
);
  localparam int NW = DIV_W + 1;

  logic [DIV_W-1:0] cnt, cnt_nx;
  logic [NW-1:0]    ratio, hi_len;
  logic             started;
  logic             hi_nx;

  always_comb begin
    ratio  = {1'b0, div_m1} + 1'b1;
    hi_len = ratio >> 1;
    if (!started)            cnt_nx = '0;
    else if (cnt >= div_m1)  cnt_nx = '0;
    else                     cnt_nx = cnt + 1'b1;
    hi_nx = ({1'b0, cnt_nx} < hi_len);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt     <= '0;
      started <= 1'b0;
      pulse_q <= 1'b0;
    end else if (run && en) begin
      cnt     <= cnt_nx;
      started <= 1'b1;
      pulse_q <= hi_nx;
    end
  end

  p_clear_low_r4: assert property (@(posedge clk)
    arst |-> !pulse_q);

  p_first_rise_r3: assert property (@(posedge clk) disable iff (arst)
    (run && en && !started && div_m1 != '0) |=> pulse_q);

  p_freeze_r5: assert property (@(posedge clk) disable iff (arst)
    (started && !en) |=> ($stable(cnt) && $stable(pulse_q)));

  p_wrap_r1: assert property (@(posedge clk) disable iff (arst)
    (run && en && started && cnt == div_m1) |=> (cnt == '0));
endmodule

// File: rtl/gated_div_clkbuf.sv
`timescale 1ns/1ps
module gated_div_clkbuf #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_in,
  input  logic                       clr,
  input  logic                       ce,
  input  logic                       clr_mask,
  input  logic                       ce_mask,
  input  logic [gdcb_pkg::DIV_W-1:0] div_sel,
  output logic                       clk_out
);
  gdcb_pkg::hold_cfg_t cfg_in, cfg;
  logic clr_eff, ce_eff;
  logic run, en;
  logic div_q;
  logic pass_gate;

  assign cfg_in = '{div_m1: div_sel, ce_bypass: ce_mask, clr_bypass: clr_mask};

  gdcb_cfg u_cfg (
    .clk     (clk_in),
    .clr_raw (clr),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg)
  );

  assign clr_eff = clr & ~cfg.clr_bypass;
  assign ce_eff  = ce | cfg.ce_bypass;

  // release of clear
  gdcb_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk  (clk_in),
    .arst (clr_eff),
    .d    (1'b1),
    .q    (run)
  );

  // both edges of enable
  gdcb_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk  (clk_in),
    .arst (clr_eff),
    .d    (ce_eff),
    .q    (en)
  );

  gdcb_divider #(.DIV_W(gdcb_pkg::DIV_W)) u_div (
    .clk     (clk_in),
    .arst    (clr_eff),
    .run     (run),
    .en      (en),
    .div_m1  (cfg.div_m1),
    .pulse_q (div_q)
  );

  // divide-by-1 gate, updated while the input is Low
  always_ff @(negedge clk_in or posedge clr_eff) begin
    if (clr_eff) pass_gate <= 1'b0;
    else         pass_gate <= run & en;
  end

  assign clk_out = (cfg.div_m1 == '0) ? (clk_in & pass_gate) : div_q;

  p_gate_clear_r9: assert property (@(posedge clk_in)
    clr_eff |-> !pass_gate);
endmodule

// File: tb/gated_div_clkbuf_test.sv
`timescale 1ns/1ps
module gated_div_clkbuf_test;
  logic       clk_in = 1'b0;
  logic       clr = 1'b1, ce = 1'b1, clr_mask = 1'b0, ce_mask = 1'b0;
  logic [2:0] div_sel = 3'd7;
  logic       clk_out;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  // select value, expected High length per period
  localparam int VEC_N = 8;
  localparam int VEC_SEL [VEC_N] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VEC_HI  [VEC_N] = '{0, 1, 1, 2, 2, 3, 3, 4};

  gated_div_clkbuf uut (
    .clk_in(clk_in), .clr(clr), .ce(ce), .clr_mask(clr_mask),
    .ce_mask(ce_mask), .div_sel(div_sel), .clk_out(clk_out)
  );

  always #5 clk_in = ~clk_in;

  task automatic step();
    @(posedge clk_in);
    #3;
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: clk_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_clear(input logic [2:0] s, input logic cem, input logic clm);
    clr = 1'b1; div_sel = s; ce_mask = cem; clr_mask = clm;
    step(); step();
  endtask

  initial begin
    // reset state
    step(); step();
    for (int i = 0; i < 3; i++) begin step(); chk(clk_out, 1'b0, "R4 reset state"); end

    // table: every ratio from a fresh release (R1 R2 R3 R9)
    for (int v = 0; v < VEC_N; v++) begin
      int n;
      n = VEC_SEL[v] + 1;
      hold_clear(VEC_SEL[v][2:0], 1'b0, 1'b0);
      clr = 1'b0;
      step(); chk(clk_out, 1'b0, "R3 low after E0");
      step(); chk(clk_out, 1'b0, "R3 low after E1");
      for (int k = 0; k < 2 * n; k++) begin
        logic e;
        step();
        e = (n == 1) ? 1'b1 : ((k % n) < VEC_HI[v]);
        chk(clk_out, e, (k == 0) ? "R3 rise at E2" : "R1 R2 waveform");
      end
    end

    // R9: low half of input in divide-by-1, then enable drop
    hold_clear(3'd0, 1'b0, 1'b0);
    clr = 1'b0;
    step(); step(); step(); chk(clk_out, 1'b1, "R9 follows input high");
    #4 chk(clk_out, 1'b0, "R9 low in input low phase");
    step(); ce = 1'b0;
    step(); chk(clk_out, 1'b1, "R9 edge0 after ce drop");
    step(); chk(clk_out, 1'b1, "R9 edge1 after ce drop");
    step(); chk(clk_out, 1'b0, "R9 gated at edge2");
    step(); chk(clk_out, 1'b0, "R9 stays gated");
    ce = 1'b1;

    // R4: asynchronous clear mid High phase
    hold_clear(3'd7, 1'b0, 1'b0);
    clr = 1'b0;
    step(); step(); step(); chk(clk_out, 1'b1, "R4 running high");
    clr = 1'b1;
    #1 chk(clk_out, 1'b0, "R4 immediate low");
    step(); chk(clk_out, 1'b0, "R4 held low");

    // R5: freeze and resume on divide-by-8
    hold_clear(3'd7, 1'b0, 1'b0);
    clr = 1'b0;
    step(); step(); step(); step(); chk(clk_out, 1'b1, "R5 k1 high");
    ce = 1'b0;
    for (int i = 0; i < 7; i++) begin step(); chk(clk_out, 1'b1, "R5 frozen high"); end
    ce = 1'b1;
    begin
      logic [6:0] exp_seq;
      exp_seq = 7'b1000011; // bit i = expected after resume edge i
      for (int i = 0; i < 7; i++) begin step(); chk(clk_out, exp_seq[i], "R5 resume"); end
    end

    // R8: select change outside clear ignored
    hold_clear(3'd7, 1'b0, 1'b0);
    clr = 1'b0;
    step(); step(); step();
    div_sel = 3'd1;
    for (int k = 1; k < 16; k++) begin step(); chk(clk_out, (k % 8) < 4, "R8 div kept at 8"); end

    // R7: enable mask with enable Low, divide-by-2
    ce = 1'b0;
    hold_clear(3'd1, 1'b1, 1'b0);
    clr = 1'b0;
    step(); chk(clk_out, 1'b0, "R7 E0");
    step(); chk(clk_out, 1'b0, "R7 E1");
    step(); chk(clk_out, 1'b1, "R7 runs with ce low");
    step(); chk(clk_out, 1'b0, "R7 toggles");
    ce_mask = 1'b0;
    step(); chk(clk_out, 1'b1, "R8 mask change ignored");
    step(); chk(clk_out, 1'b0, "R8 mask change ignored");
    ce = 1'b1;

    // R6: clear mask, divide-by-4
    hold_clear(3'd3, 1'b0, 1'b1);
    begin
      int guard = 0;
      while (clk_out !== 1'b1 && guard < 10) begin step(); guard++; end
    end
    chk(clk_out, 1'b1, "R6 runs while clr high");
    clr = 1'b0; #1 clr = 1'b1;
    #1 chk(clk_out, 1'b1, "R6 clear ignored");
    begin
      int highs = 0;
      for (int i = 0; i < 8; i++) begin step(); if (clk_out === 1'b1) highs++; end
      chk(highs == 4, 1'b1, "R6 div4 keeps running");
    end
    clr_mask = 1'b0;
    step(); chk(clk_out, 1'b0, "R6 unmask returns to clear");
    step(); chk(clk_out, 1'b0, "R6 held in clear");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule